// File: doc/BRIEF.md
# Video Output Formatter With Cropping

This block sits at the end of a line-locked video decoding pipeline. It takes one 10-bit luma sample and one 10-bit chroma sample on every pixel clock and drives the parallel digital video pins. Each sample is limited to a selectable coding range. A programmable horizontal window forms an active-video gate (`vid_avid`), and a downstream device uses that gate as a write enable. Samples outside the gate are replaced by black.

In embedded-sync mode the gate covers only the horizontal window. Lines in vertical blanking still carry their content, so data carried in the blanking interval is kept. In discrete-sync mode a programmable line window also masks vertical blanking. The block can also put chroma and luma onto a single multiplexed bus, truncate the output to 8 significant bits, and force black while no input signal is present. Enable flags for the data pins and the clock pin come up disabled after reset.

Sample position is counted from strobes. `line_start` marks pixel 0 of a line. `field_start` marks line 0 of a field, and it is asserted together with that line's `line_start`. Output timing follows these strobes whether or not a signal is present.

Top module: `video_out_fmt`

## Requirements
- R1: With `cfg_narrow` low (extended range), each output sample on `vid_y` and `vid_c` is limited to the codes 4 to 1016.
- R2: With `cfg_narrow` high (standard range), luma is limited to 64 to 940 and chroma to 64 to 960.
- R3: Each output appears exactly one clock after its input sample. It is registered on the rising edge that captures the input.
- R4: The pixel index is 0 on the clock where `line_start` is high and rises by one each clock after that. `vid_avid` is high when `cfg_avid_start <= index < cfg_avid_stop`. Outside that window the outputs are black: Y = 64 and C = 512.
- R5: With `cfg_discrete` low, lines outside the vertical window pass through (clamped), and `vid_avid` follows only the horizontal window.
- R6: With `cfg_discrete` high, the line index is 0 on the `field_start` line and rises by one on each later `line_start`. Lines whose index is below `cfg_vact_start`, or not below `cfg_vact_stop`, are black, and `vid_avid` is low on them.
- R7: With `cfg_mux` high, `vid_y` carries chroma and luma in turn. The first sample in the window is chroma, so the order is C, Y, C, Y. `vid_c` holds 512.
- R8: With `cfg_8bit` high, bits [1:0] of both outputs are 0, and bits [9:2] carry the clamped sample.
- R9: While `sig_present` is low, the outputs are black but `vid_avid` keeps its normal timing.
- R10: `data_oe` and `clk_oe` are 0 after reset. Each one follows its configuration bit one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | Marks pixel 0 of a line |
| field_start | input | 1 | Marks line 0 of a field |
| sig_present | input | 1 | Input video detected |
| in_y | input | 10 | Luma sample |
| in_c | input | 10 | Chroma sample |
| cfg_narrow | input | 1 | 1 = standard coding range, 0 = extended |
| cfg_discrete | input | 1 | 1 = discrete syncs (vertical masking on) |
| cfg_mux | input | 1 | 1 = chroma/luma multiplexed on vid_y |
| cfg_8bit | input | 1 | 1 = clear the two LSBs |
| cfg_data_oe | input | 1 | Data pin enable request |
| cfg_clk_oe | input | 1 | Clock pin enable request |
| cfg_avid_start | input | 11 | First active pixel |
| cfg_avid_stop | input | 11 | First pixel after the active window |
| cfg_vact_start | input | 11 | First active line |
| cfg_vact_stop | input | 11 | First line after the active lines |
| vid_y | output | 10 | Luma or multiplexed output |
| vid_c | output | 10 | Chroma output |
| vid_avid | output | 1 | Active-video gate |
| data_oe | output | 1 | Data pin enable |
| clk_oe | output | 1 | Clock pin enable |

## Verification
All results of this block are due one clock after their stimulus: clamped data, black substitution, the gate, the multiplex phase and the enable flags. The bench drives each sample on a falling edge and lets one rising edge capture it. It compares the outputs on the next falling edge, so every check lands on the single register stage. Pixel and line indices are tracked in the bench from the strobes it drives, so the expected window edges come straight from the configured start and stop values.

// File: rtl/video_out_fmt.sv
module video_out_fmt #(
  parameter int DW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          field_start,
  input  logic          sig_present,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_c,
  input  logic          cfg_narrow,
  input  logic          cfg_discrete,
  input  logic          cfg_mux,
  input  logic          cfg_8bit,
  input  logic          cfg_data_oe,
  input  logic          cfg_clk_oe,
  input  logic [CW-1:0] cfg_avid_start,
  input  logic [CW-1:0] cfg_avid_stop,
  input  logic [CW-1:0] cfg_vact_start,
  input  logic [CW-1:0] cfg_vact_stop,
  output logic [DW-1:0] vid_y,
  output logic [DW-1:0] vid_c,
  output logic          vid_avid,
  output logic          data_oe,
  output logic          clk_oe
);
  localparam int SH = DW - 8;
  localparam logic [DW-1:0] EXT_LO  = DW'(1 << SH);
  localparam logic [DW-1:0] EXT_HI  = DW'(254 << SH);
  localparam logic [DW-1:0] STD_LO  = DW'(16 << SH);
  localparam logic [DW-1:0] STD_YHI = DW'(235 << SH);
  localparam logic [DW-1:0] STD_CHI = DW'(240 << SH);
  localparam logic [DW-1:0] BLK_Y   = DW'(16 << SH);
  localparam logic [DW-1:0] BLK_C   = DW'(128 << SH);
  localparam logic [DW-1:0] LSB_CUT = ~DW'((1 << SH) - 1);

  function automatic logic [DW-1:0] clip(input logic [DW-1:0] v,
                                         input logic [DW-1:0] lo,
                                         input logic [DW-1:0] hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  logic [CW-1:0] pix_q, line_q, pix_c, line_c;
  logic          phase_q, phase_c, hact, vact, avid_c, show;
  logic [DW-1:0] y_lim, c_lim, y_nxt, c_nxt, oy_nxt, oc_nxt, keep;

  assign pix_c   = line_start ? '0 : pix_q + CW'(1);
  assign line_c  = field_start ? '0 : (line_start ? line_q + CW'(1) : line_q);
  assign hact    = (pix_c >= cfg_avid_start) && (pix_c < cfg_avid_stop);
  assign vact    = (line_c >= cfg_vact_start) && (line_c < cfg_vact_stop);
  assign avid_c  = hact && (!cfg_discrete || vact);
  assign show    = avid_c && sig_present;
  assign phase_c = (pix_c == cfg_avid_start) ? 1'b0 : ~phase_q;

  assign y_lim  = cfg_narrow ? clip(in_y, STD_LO, STD_YHI) : clip(in_y, EXT_LO, EXT_HI);
  assign c_lim  = cfg_narrow ? clip(in_c, STD_LO, STD_CHI) : clip(in_c, EXT_LO, EXT_HI);
  assign y_nxt  = show ? y_lim : BLK_Y;
  assign c_nxt  = show ? c_lim : BLK_C;
  assign keep   = cfg_8bit ? LSB_CUT : '1;
  assign oy_nxt = (cfg_mux ? (phase_c ? y_nxt : c_nxt) : y_nxt) & keep;
  assign oc_nxt = (cfg_mux ? BLK_C : c_nxt) & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q    <= '1;
      line_q   <= '0;
      phase_q  <= 1'b1;
      vid_y    <= BLK_Y;
      vid_c    <= BLK_C;
      vid_avid <= 1'b0;
      data_oe  <= 1'b0;
      clk_oe   <= 1'b0;
    end else begin
      pix_q    <= pix_c;
      line_q   <= line_c;
      phase_q  <= phase_c;
      vid_y    <= oy_nxt;
      vid_c    <= oc_nxt;
      vid_avid <= avid_c;
      data_oe  <= cfg_data_oe;
      clk_oe   <= cfg_clk_oe;
    end
  end

  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_y >= EXT_LO && vid_y <= EXT_HI && vid_c >= EXT_LO && vid_c <= EXT_HI); // R1
  AST_STD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_narrow && !cfg_mux) |-> vid_y >= STD_LO && vid_y <= STD_YHI
      && vid_c >= STD_LO && vid_c <= STD_CHI); // R2
  AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_avid && !$past(cfg_mux)) |-> vid_y == BLK_Y && vid_c == BLK_C); // R4
  AST_MUX_CHROMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_mux) |-> vid_c == BLK_C); // R7
  AST_LSB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_8bit) |-> vid_y[1:0] == 2'b00 && vid_c[1:0] == 2'b00); // R8
  AST_NOSIG_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sig_present) |-> vid_c == BLK_C); // R9
endmodule

// File: tb/video_out_fmt_tb.sv
module video_out_fmt_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 0, field_start = 0, sig_present = 1;
  logic [9:0] in_y = '0, in_c = '0;
  logic cfg_narrow = 0, cfg_discrete = 0, cfg_mux = 0, cfg_8bit = 0;
  logic cfg_data_oe = 0, cfg_clk_oe = 0;
  logic [10:0] cfg_avid_start = 11'd4, cfg_avid_stop = 11'd8;
  logic [10:0] cfg_vact_start = 11'd2, cfg_vact_stop = 11'd5;
  logic [9:0] vid_y, vid_c;
  logic vid_avid, data_oe, clk_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_out_fmt dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit ls, input bit fs, input int y, input int c);
    line_start = ls; field_start = fs; in_y = 10'(y); in_c = 10'(c);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit in_win(input int p);
    return p >= 4 && p < 8;
  endfunction

  task automatic t_reset_oe;
    check("R10 data_oe reset", data_oe, 0);
    check("R10 clk_oe reset", clk_oe, 0);
    check("R4 reset Y black", vid_y, 64);
    check("R4 reset C black", vid_c, 512);
    check("R4 reset avid", vid_avid, 0);
    cfg_data_oe = 1;
    step(0, 0, 0, 0);
    check("R10 data_oe follows", data_oe, 1);
    check("R10 clk_oe stays", clk_oe, 0);
    cfg_clk_oe = 1;
    step(0, 0, 0, 0);
    check("R10 clk_oe follows", clk_oe, 1);
  endtask

  task automatic t_ext;
    for (int p = 0; p < 12; p++) begin
      int y = (p == 4) ? 0 : (p == 5) ? 1023 : 200 + p;
      int c = (p == 4) ? 1 : (p == 5) ? 1020 : 600 + p;
      step(p == 0, p == 0, y, c);
      check("R4 avid window", vid_avid, in_win(p));
      if (p == 4) begin
        check("R1 Y low clamp", vid_y, 4); check("R1 C low clamp", vid_c, 4);
      end else if (p == 5) begin
        check("R1 Y high clamp", vid_y, 1016); check("R1 C high clamp", vid_c, 1016);
      end else if (in_win(p)) begin
        check("R3 Y pass", vid_y, 200 + p); check("R3 C pass", vid_c, 600 + p);
      end else begin
        check("R4 Y black", vid_y, 64); check("R4 C black", vid_c, 512);
      end
    end
  endtask

  task automatic t_std;
    cfg_narrow = 1;
    for (int p = 0; p < 12; p++) begin
      int y = (p == 4) ? 0 : (p == 5) ? 1023 : 500;
      step(p == 0, p == 0, y, y);
      if (p == 4) begin
        check("R2 Y low", vid_y, 64); check("R2 C low", vid_c, 64);
      end
      if (p == 5) begin
        check("R2 Y high", vid_y, 940); check("R2 C high", vid_c, 960);
      end
    end
    cfg_narrow = 0;
  endtask

  task automatic t_vert(input bit disc);
    cfg_discrete = disc;
    for (int ln = 0; ln < 6; ln++)
      for (int p = 0; p < 12; p++) begin
        step(p == 0, ln == 0 && p == 0, 300, 700);
        if (p == 5) begin
          bit act = !disc || (ln >= 2 && ln < 5);
          if (disc) begin
            check("R6 vertical avid", vid_avid, act);
            check("R6 vertical Y", vid_y, act ? 300 : 64);
          end else begin
            check("R5 embedded avid", vid_avid, 1);
            check("R5 embedded Y", vid_y, 300);
          end
        end
      end
    cfg_discrete = 0;
  endtask

  task automatic t_mux;
    cfg_mux = 1;
    for (int p = 0; p < 12; p++) begin
      step(p == 0, p == 0, 100 + p, 600 + p);
      check("R7 C idle", vid_c, 512);
      if (in_win(p))
        check("R7 mux order", vid_y, (p % 2 == 0) ? 600 + p : 100 + p);
    end
    cfg_mux = 0;
  endtask

  task automatic t_8bit;
    cfg_8bit = 1;
    for (int p = 0; p < 12; p++) begin
      step(p == 0, p == 0, (p == 4) ? 'h203 : 'h155, (p == 4) ? 'h1FF : 'h155);
      if (p == 4) begin
        check("R8 Y lsb", vid_y, 'h200); check("R8 C lsb", vid_c, 'h1FC);
      end
      if (p == 9) check("R8 black Y", vid_y, 64);
    end
    cfg_8bit = 0;
  endtask

  task automatic t_nosig;
    sig_present = 0;
    for (int p = 0; p < 12; p++) begin
      step(p == 0, p == 0, 700, 700);
      if (p == 5) begin
        check("R9 Y black", vid_y, 64);
        check("R9 C black", vid_c, 512);
        check("R9 avid kept", vid_avid, 1);
      end
    end
    sig_present = 1;
    step(1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_oe();
    t_ext();
    t_std();
    t_vert(0);
    t_vert(1);
    t_mux();
    t_8bit();
    t_nosig();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule